// File: doc/BRIEF.md
# Two-Receiver Weaver SSB Audio Demodulator

This block sits after a pair of audio down-converters, each delivering complex baseband I/Q samples of about 22 kHz bandwidth at 48 kHz. For every input sample pair it can narrow both receivers to about 6 kHz or 3 kHz with boxcar lowpass filters, or leave the full band untouched. It then recovers single-sideband audio by the Weaver method. A quadrature oscillator at half the chosen bandwidth mixes the filtered I and Q, and the two products are added or subtracted.

Each receiver's audio always goes to a processor-side stream. A stereo headphone stream carries receiver 0, receiver 1, their saturated sum, or one receiver on each side, as the route input selects. One shared valid strobe marks new input samples. One output strobe marks new audio on both streams.

Top module: `weaver_ssb_rx`

## Requirements
- R1: While rst_ni is low and after its release, until the first sample is processed, out_valid_o is 0 and every audio output is 0.
- R2: An input sample taken on a rising edge with in_valid_i high produces a one-cycle out_valid_o pulse after the second rising edge that follows. out_valid_o is low at all other times.
- R3: bw_sel_i selects the prefilter: 1 gives the floor of the mean of the 4 most recent samples (about 6 kHz), 2 gives the floor of the mean of the 8 most recent samples (about 3 kHz), and 0 or 3 passes the sample through (22 kHz). Only samples with in_valid_i high enter the filter history.
- R4: A sample whose bw_sel_i differs from that of the previous sample treats all filter history as zero and restarts the oscillator phase at 0. The new setting applies to that sample.
- R5: The oscillator is a 32-bit phase accumulator that resets to 0. Its increment is round(f·2^32/48000), with f = 3000 Hz for bw_sel_i 1, 1500 Hz for 2 and 11000 Hz otherwise. A sample uses the top 6 accumulator bits from before its own increment, and the phase advances only on valid samples.
- R6: With c = round(32767·cos(2π·k/64)) and s = round(32767·sin(2π·k/64)) at phase index k, a receiver's audio is floor((I·c + Q·s)/2^17) when its bit of sideband_i is 1 (upper), and floor((I·c − Q·s)/2^17) when the bit is 0 (lower). The result is saturated to signed 16 bits. Bit 0 of sideband_i is receiver 0.
- R7: cpu_rx0_o and cpu_rx1_o carry receiver 0 and receiver 1 audio, whatever the route.
- R8: route_i 0 puts receiver 0 audio on both headphone channels, and route_i 1 puts receiver 1 on both.
- R9: route_i 2 puts the sum of both receivers, formed in 17 bits and saturated to signed 16 bits, on both headphone channels.
- R10: route_i 3 puts receiver 0 on hp_left_o and receiver 1 on hp_right_o.
- R11: All audio outputs hold their values between out_valid_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | New I/Q sample on both receivers |
| rx0_i_i | input | 18 | Receiver 0 in-phase, signed |
| rx0_q_i | input | 18 | Receiver 0 quadrature, signed |
| rx1_i_i | input | 18 | Receiver 1 in-phase, signed |
| rx1_q_i | input | 18 | Receiver 1 quadrature, signed |
| bw_sel_i | input | 2 | Prefilter bandwidth select |
| sideband_i | input | 2 | Per-receiver sideband, 1 = upper |
| route_i | input | 2 | Headphone routing mode |
| out_valid_o | output | 1 | New audio on all outputs |
| hp_left_o | output | 16 | Headphone left, signed |
| hp_right_o | output | 16 | Headphone right, signed |
| cpu_rx0_o | output | 16 | Processor stream, receiver 0 |
| cpu_rx1_o | output | 16 | Processor stream, receiver 1 |

## Verification
Filtered values and the phase index are registered on the sampling edge. Mixing, routing and the output registers act on the next edge, so audio is due after the second rising edge, and sideband_i and route_i are taken at that second edge. The bench drives each sample on a falling edge and holds the controls steady. It checks that out_valid_o is low one falling edge later and compares the audio one falling edge after that. On the following falling edge it checks that the strobe has dropped and the outputs have held. The per-receiver audio is compared against a bench model with a small tolerance for oscillator rounding. The headphone channels are compared exactly against the routing rule applied to the observed processor-stream values.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int OSC_W  = 16;
  localparam int LUT_AW = 6;

  typedef enum logic [1:0] {RT_RX0 = 2'd0, RT_RX1 = 2'd1, RT_MIX = 2'd2, RT_STEREO = 2'd3} route_e;
  typedef enum logic [1:0] {BW_WIDE = 2'd0, BW_MID = 2'd1, BW_NARROW = 2'd2, BW_WIDE2 = 2'd3} bw_e;

  // first quadrant of a 64-step sine, amplitude 32767
  function automatic logic signed [OSC_W-1:0] quarter_sine(input logic [4:0] k);
    case (k)
      5'd0:  return 16'sd0;
      5'd1:  return 16'sd3212;
      5'd2:  return 16'sd6393;
      5'd3:  return 16'sd9512;
      5'd4:  return 16'sd12539;
      5'd5:  return 16'sd15446;
      5'd6:  return 16'sd18204;
      5'd7:  return 16'sd20787;
      5'd8:  return 16'sd23170;
      5'd9:  return 16'sd25329;
      5'd10: return 16'sd27245;
      5'd11: return 16'sd28898;
      5'd12: return 16'sd30273;
      5'd13: return 16'sd31356;
      5'd14: return 16'sd32137;
      5'd15: return 16'sd32609;
      default: return 16'sd32767;
    endcase
  endfunction

  function automatic logic signed [OSC_W-1:0] osc_sin(input logic [LUT_AW-1:0] p);
    logic [4:0] k, km;
    k  = {1'b0, p[3:0]};
    km = 5'd16 - k;
    case (p[5:4])
      2'd0:    return quarter_sine(k);
      2'd1:    return quarter_sine(km);
      2'd2:    return -quarter_sine(k);
      default: return -quarter_sine(km);
    endcase
  endfunction

  function automatic logic signed [OSC_W-1:0] osc_cos(input logic [LUT_AW-1:0] p);
    return osc_sin(p + LUT_AW'(16));
  endfunction
endpackage

// File: rtl/ssb_band_filter.sv
module ssb_band_filter #(
  parameter int IN_W     = 18,
  parameter int MAX_TAPS = 8,
  parameter int LG_W     = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic                   clear_i,
  input  logic [LG_W-1:0]        lg_taps_i,
  input  logic signed [IN_W-1:0] x_i,
  output logic signed [IN_W-1:0] y_o
);
  localparam int LG_MAX = $clog2(MAX_TAPS);
  localparam int SW     = IN_W + LG_MAX + 1;
  localparam int HD     = MAX_TAPS - 1;

  logic signed [IN_W-1:0] hist_q [HD];
  logic signed [SW-1:0]   sum_d;
  logic signed [IN_W-1:0] y_d;
  logic signed [IN_W-1:0] y_q;

  always_comb begin
    int ntap;
    ntap  = 1 << lg_taps_i;
    sum_d = SW'(x_i);
    for (int j = 0; j < HD; j++)
      if (!clear_i && (j < ntap - 1)) sum_d = sum_d + SW'(hist_q[j]);
    y_d = IN_W'(sum_d >>> lg_taps_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < HD; j++) hist_q[j] <= '0;
      y_q <= '0;
    end else if (step_i) begin
      hist_q[0] <= x_i;
      for (int j = 1; j < HD; j++) hist_q[j] <= clear_i ? '0 : hist_q[j-1];
      y_q <= y_d;
    end
  end

  assign y_o = y_q;

  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && lg_taps_i == '0) |=> (y_o == $past(x_i))); // R3
  AST_FILT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(y_o)); // R3
endmodule

// File: rtl/ssb_nco.sv
module ssb_nco #(
  parameter int PH_W   = 32,
  parameter int IDX_W  = 6,
  parameter int FS_HZ  = 48000,
  parameter int F_WIDE = 11000,
  parameter int F_MID  = 3000,
  parameter int F_NAR  = 1500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  input  logic [1:0]       bw_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [PH_W-1:0] INC_WIDE = PH_W'(((64'(F_WIDE) << PH_W) + 64'(FS_HZ / 2)) / 64'(FS_HZ));
  localparam logic [PH_W-1:0] INC_MID  = PH_W'(((64'(F_MID)  << PH_W) + 64'(FS_HZ / 2)) / 64'(FS_HZ));
  localparam logic [PH_W-1:0] INC_NAR  = PH_W'(((64'(F_NAR)  << PH_W) + 64'(FS_HZ / 2)) / 64'(FS_HZ));

  logic [PH_W-1:0]  acc_q, base_d, inc_d;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    case (bw_i)
      2'd1:    inc_d = INC_MID;
      2'd2:    inc_d = INC_NAR;
      default: inc_d = INC_WIDE;
    endcase
    base_d = clear_i ? '0 : acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (step_i) begin
      acc_q <= base_d + inc_d;
      idx_q <= base_d[PH_W-1 -: IDX_W];
    end
  end

  assign idx_o = idx_q;

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(acc_q)); // R5
  AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && clear_i) |=> (idx_o == '0)); // R4
endmodule

// File: rtl/ssb_weaver_mix.sv
module ssb_weaver_mix
  import ssb_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  i_i,
  input  logic signed [IN_W-1:0]  q_i,
  input  logic [LUT_AW-1:0]       idx_i,
  input  logic                    upper_i,
  output logic signed [OUT_W-1:0] audio_o
);
  localparam int PW = IN_W + OSC_W;
  localparam int SW = PW + 1;
  localparam int SH = OSC_W - 1 + IN_W - OUT_W;

  logic signed [OSC_W-1:0] c_v, s_v;
  logic signed [PW-1:0]    p_c, p_s;
  logic signed [SW-1:0]    sum_d, shf_d;
  logic                    fits;

  assign c_v   = osc_cos(idx_i);
  assign s_v   = osc_sin(idx_i);
  assign p_c   = PW'(i_i) * PW'(c_v);
  assign p_s   = PW'(q_i) * PW'(s_v);
  assign sum_d = upper_i ? (SW'(p_c) + SW'(p_s)) : (SW'(p_c) - SW'(p_s));
  assign shf_d = sum_d >>> SH;
  assign fits  = (&shf_d[SW-1:OUT_W-1]) || !(|shf_d[SW-1:OUT_W-1]);

  always_comb begin
    if (fits)           audio_o = shf_d[OUT_W-1:0];
    else if (shf_d[SW-1]) audio_o = {1'b1, {(OUT_W-1){1'b0}}};
    else                audio_o = {1'b0, {(OUT_W-1){1'b1}}};
  end
endmodule

// File: rtl/ssb_router.sv
module ssb_router
  import ssb_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic signed [OUT_W-1:0] a_i,
  input  logic signed [OUT_W-1:0] b_i,
  input  logic [1:0]              route_i,
  output logic signed [OUT_W-1:0] left_o,
  output logic signed [OUT_W-1:0] right_o
);
  logic signed [OUT_W:0]   sum_d;
  logic signed [OUT_W-1:0] mix_d;

  assign sum_d = (OUT_W+1)'(a_i) + (OUT_W+1)'(b_i);

  always_comb begin
    if (sum_d[OUT_W] == sum_d[OUT_W-1]) mix_d = sum_d[OUT_W-1:0];
    else if (sum_d[OUT_W])              mix_d = {1'b1, {(OUT_W-1){1'b0}}};
    else                                mix_d = {1'b0, {(OUT_W-1){1'b1}}};
    case (route_e'(route_i))
      RT_RX0:    begin left_o = a_i;   right_o = a_i;   end
      RT_RX1:    begin left_o = b_i;   right_o = b_i;   end
      RT_MIX:    begin left_o = mix_d; right_o = mix_d; end
      default:   begin left_o = a_i;   right_o = b_i;   end
    endcase
  end
endmodule

// File: rtl/weaver_ssb_rx.sv
module weaver_ssb_rx
  import ssb_pkg::*;
#(
  parameter int IN_W     = 18,
  parameter int OUT_W    = 16,
  parameter int TAPS_MID = 4,
  parameter int TAPS_NAR = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  rx0_i_i,
  input  logic signed [IN_W-1:0]  rx0_q_i,
  input  logic signed [IN_W-1:0]  rx1_i_i,
  input  logic signed [IN_W-1:0]  rx1_q_i,
  input  logic [1:0]              bw_sel_i,
  input  logic [1:0]              sideband_i,
  input  logic [1:0]              route_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] hp_left_o,
  output logic signed [OUT_W-1:0] hp_right_o,
  output logic signed [OUT_W-1:0] cpu_rx0_o,
  output logic signed [OUT_W-1:0] cpu_rx1_o
);
  localparam int NRX      = 2;
  localparam int MAX_TAPS = (TAPS_NAR > TAPS_MID) ? TAPS_NAR : TAPS_MID;
  localparam int LG_W     = $clog2($clog2(MAX_TAPS) + 1);
  localparam logic [LG_W-1:0] LG_MID = LG_W'($clog2(TAPS_MID));
  localparam logic [LG_W-1:0] LG_NAR = LG_W'($clog2(TAPS_NAR));

  logic signed [IN_W-1:0]  xin  [NRX][2];
  logic signed [IN_W-1:0]  filt [NRX][2];
  logic signed [OUT_W-1:0] aud  [NRX];
  logic signed [OUT_W-1:0] left_d, right_d;
  logic [LUT_AW-1:0]       ph_idx;
  logic [1:0]              bw_q;
  logic                    bw_clear;
  logic [LG_W-1:0]         lg_taps;
  logic                    s1_valid_q, out_valid_q;
  logic signed [OUT_W-1:0] hp_l_q, hp_r_q, cpu0_q, cpu1_q;

  assign xin[0][0] = rx0_i_i;
  assign xin[0][1] = rx0_q_i;
  assign xin[1][0] = rx1_i_i;
  assign xin[1][1] = rx1_q_i;

  assign bw_clear = in_valid_i && (bw_sel_i != bw_q);

  always_comb begin
    case (bw_e'(bw_sel_i))
      BW_MID:    lg_taps = LG_MID;
      BW_NARROW: lg_taps = LG_NAR;
      default:   lg_taps = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bw_q       <= 2'd0;
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= in_valid_i;
      if (in_valid_i) bw_q <= bw_sel_i;
    end
  end

  for (genvar r = 0; r < NRX; r++) begin : g_rx
    for (genvar c = 0; c < 2; c++) begin : g_comp
      ssb_band_filter #(.IN_W(IN_W), .MAX_TAPS(MAX_TAPS), .LG_W(LG_W)) u_filt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (in_valid_i),
        .clear_i   (bw_clear),
        .lg_taps_i (lg_taps),
        .x_i       (xin[r][c]),
        .y_o       (filt[r][c])
      );
    end
    ssb_weaver_mix #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mix (
      .i_i     (filt[r][0]),
      .q_i     (filt[r][1]),
      .idx_i   (ph_idx),
      .upper_i (sideband_i[r]),
      .audio_o (aud[r])
    );
  end

  ssb_nco #(.IDX_W(LUT_AW)) u_nco (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (in_valid_i),
    .clear_i (bw_clear),
    .bw_i    (bw_sel_i),
    .idx_o   (ph_idx)
  );

  ssb_router #(.OUT_W(OUT_W)) u_route (
    .a_i     (aud[0]),
    .b_i     (aud[1]),
    .route_i (route_i),
    .left_o  (left_d),
    .right_o (right_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      hp_l_q      <= '0;
      hp_r_q      <= '0;
      cpu0_q      <= '0;
      cpu1_q      <= '0;
    end else begin
      out_valid_q <= s1_valid_q;
      if (s1_valid_q) begin
        hp_l_q <= left_d;
        hp_r_q <= right_d;
        cpu0_q <= aud[0];
        cpu1_q <= aud[1];
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign hp_left_o   = hp_l_q;
  assign hp_right_o  = hp_r_q;
  assign cpu_rx0_o   = cpu0_q;
  assign cpu_rx1_o   = cpu1_q;

  AST_STAGE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> s1_valid_q); // R2
  AST_STAGE_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q |=> out_valid_o); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_q |=> ($stable(hp_left_o) && $stable(cpu_rx0_o) && $stable(cpu_rx1_o))); // R11
  AST_MONO_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && route_i != RT_STEREO) |=> (hp_left_o == hp_right_o)); // R9
endmodule

// File: tb/sim_weaver_ssb_rx.sv
`timescale 1ns/1ps
module sim_weaver_ssb_rx;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [17:0] i0, q0, i1, q1;
  logic [1:0] bw, sb, rt;
  logic out_valid;
  logic signed [15:0] hp_l, hp_r, cpu0, cpu1;

  always #2 clk = ~clk;

  weaver_ssb_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .rx0_i_i(i0), .rx0_q_i(q0), .rx1_i_i(i1), .rx1_q_i(q1),
    .bw_sel_i(bw), .sideband_i(sb), .route_i(rt),
    .out_valid_o(out_valid), .hp_left_o(hp_l), .hp_right_o(hp_r),
    .cpu_rx0_o(cpu0), .cpu_rx1_o(cpu1)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int hist [2][2][7];
  int bw_prev = 0;
  logic [31:0] acc_m = '0;

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int osc(int idx, bit cosine);
    real ang, v;
    ang = 2.0 * 3.14159265358979 * idx / 64.0;
    v = cosine ? $cos(ang) : $sin(ang);
    return $rtoi(v * 32767.0 + (v >= 0.0 ? 0.5 : -0.5));
  endfunction

  function automatic logic [31:0] inc_for(int b);
    longint f;
    f = (b == 1) ? 3000 : (b == 2) ? 1500 : 11000;
    return 32'(((f << 32) + 24000) / 48000);
  endfunction

  task automatic check(string req, int act, int exp, int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int a_i, int a_q, int b_i, int b_q, int b, logic [1:0] s, int r);
    int x [2][2];
    int y [2][2];
    int n, lg, idx, c, sn;
    int e [2];
    int el, er, hold_l;
    longint sum;
    x[0][0] = a_i; x[0][1] = a_q; x[1][0] = b_i; x[1][1] = b_q;
    // model: R3 R4 R5 R6
    if (b != bw_prev) begin
      for (int rr = 0; rr < 2; rr++) for (int cc = 0; cc < 2; cc++)
        for (int j = 0; j < 7; j++) hist[rr][cc][j] = 0;
      acc_m = '0;
    end
    n  = (b == 1) ? 4 : (b == 2) ? 8 : 1;
    lg = (b == 1) ? 2 : (b == 2) ? 3 : 0;
    for (int rr = 0; rr < 2; rr++) for (int cc = 0; cc < 2; cc++) begin
      int s_acc;
      s_acc = x[rr][cc];
      for (int j = 0; j < n - 1; j++) s_acc += hist[rr][cc][j];
      y[rr][cc] = s_acc >>> lg;
      for (int j = 6; j > 0; j--) hist[rr][cc][j] = hist[rr][cc][j-1];
      hist[rr][cc][0] = x[rr][cc];
    end
    idx = int'(acc_m[31:26]);
    acc_m = acc_m + inc_for(b);
    bw_prev = b;
    c  = osc(idx, 1'b1);
    sn = osc(idx, 1'b0);
    for (int rr = 0; rr < 2; rr++) begin
      sum = longint'(y[rr][0]) * c;
      if (s[rr]) sum = sum + longint'(y[rr][1]) * sn;
      else       sum = sum - longint'(y[rr][1]) * sn;
      e[rr] = sat16(sum >>> 17);
    end
    @(negedge clk);
    i0 = 18'(a_i); q0 = 18'(a_q); i1 = 18'(b_i); q1 = 18'(b_q);
    bw = 2'(b); sb = s; rt = 2'(r); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid early", int'(out_valid), 0, 0);
    @(negedge clk);
    check("R2 valid due", int'(out_valid), 1, 0);
    check("R6 rx0 audio", int'(cpu0), e[0], 3);
    check("R7 rx1 audio", int'(cpu1), e[1], 3);
    case (r)
      0: begin el = cpu0; er = cpu0; end
      1: begin el = cpu1; er = cpu1; end
      2: begin el = sat16(longint'(cpu0) + longint'(cpu1)); er = el; end
      default: begin el = cpu0; er = cpu1; end
    endcase
    if (r == 2) begin
      check("R9 mix left", int'(hp_l), el, 0);
      check("R9 mix right", int'(hp_r), er, 0);
    end else if (r == 3) begin
      check("R10 stereo left", int'(hp_l), el, 0);
      check("R10 stereo right", int'(hp_r), er, 0);
    end else begin
      check("R8 mono left", int'(hp_l), el, 0);
      check("R8 mono right", int'(hp_r), er, 0);
    end
    hold_l = hp_l;
    @(negedge clk);
    check("R2 valid pulse", int'(out_valid), 0, 0);
    check("R11 hold", int'(hp_l), hold_l, 0);
  endtask

  function automatic int rnd18();
    return int'($urandom_range(0, 262143)) - 131072;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0;
    i0 = '0; q0 = '0; i1 = '0; q1 = '0; bw = '0; sb = '0; rt = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0, 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 valid", int'(out_valid), 0, 0);
    check("R1 hp_left", int'(hp_l), 0, 0);
    check("R1 hp_right", int'(hp_r), 0, 0);
    check("R1 cpu0", int'(cpu0), 0, 0);
    check("R1 cpu1", int'(cpu1), 0, 0);

    // R3 bypass, phase 0, route rx0 / rx1
    send(120000, 0, -60000, 5000, 0, 2'b11, 0);
    send(40000, 40000, 40000, -40000, 0, 2'b01, 1);
    // R9 mix saturation after a restart at phase 0
    send(10, 10, 10, 10, 3, 2'b00, 0);
    send(131071, 0, 131071, 0, 0, 2'b00, 2);
    send(-131072, 0, -131072, 0, 0, 2'b11, 2);
    // R3 R4 averaging with a change of width; R6 saturation on the rails
    for (int k = 0; k < 12; k++) send(-131072, -131072, 131071, 131071, 1, 2'b01, 3);
    for (int k = 0; k < 12; k++) send(100000, -100000, 4000 * k, 7000, 2, 2'b10, 2);
    for (int k = 0; k < 5; k++) send(3000 * k, -2000, 1000, 9000, 1, 2'b11, 3);
    // constrained random
    for (int k = 0; k < 400; k++) begin
      int b;
      b = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 3)) : bw_prev;
      send(rnd18(), rnd18(), rnd18(), rnd18(), b,
           2'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule